// File: doc/BRIEF.md
# PWM Timer Channel

This block is one channel of a pulse-width timer attached to a simple memory-mapped bus with 32-bit registers and no wait states. A free-running counter advances once per clock while the channel is running. A low reference register sets the last count of each period, after which the counter restarts at zero. A high reference register sets the count at which the output switches from low to high within the period. The output is therefore active-low in the sense that each period opens low and closes high. Software adjusts the duty by moving the high reference.

A control register runs the channel and gates its output. It also selects single-run operation, enables the interrupt and holds the interrupt flag. A further bit holds the counter at zero. Three more bits, for external clock select, edge select and capture enable, are stored and read back but have no effect. A full timer would place eight of these channels side by side. Address decoding across channels sits outside this block.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset all four registers read zero, and `pwm_out` and `irq` are low.
- R2: Register words are selected by `paddr[3:2]`: 0 counter, 1 high reference, 2 low reference, 3 control. A write completes when `psel`, `penable` and `pwrite` are high together. `prdata` shows the selected word combinationally, with the live counter value. `pready` is always high. An address with nonzero `paddr[1:0]`, or nonzero bits above bit 3, is not written and reads zero.
- R3: While running (control bit0 run and bit3 output-enable both set), the counter adds one per clock. When the counter equals the low reference, it restarts at zero on the next clock.
- R4: While running, `pwm_out` goes high on the clock after the counter equals the high reference. It goes low on the clock after the counter equals the low reference. A low-reference match takes priority when both match.
- R5: While not running, the counter keeps its value and no match events occur.
- R6: When a control write clears bit0 or bit3, `pwm_out` is low from the clock edge of that write onward.
- R7: A low-reference match while control bit5 (interrupt enable) is set sets control bit6 (interrupt flag). `irq` equals bit6 AND bit5.
- R8: A control write with bit6 = 0 clears the flag. A control write with bit6 = 1 leaves the flag unchanged. A match in the same cycle as a clearing write still sets the flag.
- R9: With control bit4 (single-run) set, a low-reference match clears control bit0, and counting stops.
- R10: While control bit7 (counter clear) is set, the counter reads zero on the next clock and match events are suppressed.
- R11: A write to the counter word loads the written value. Counter clear takes priority over this load.
- R12: Control bits 1, 2 and 8 are stored and read back, and they leave counting and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Channel select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | ADDR_W | Byte address within the channel |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data of the addressed word |
| pready | output | 1 | Transfer complete, always high |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for counter increment and hold, restart after a low-reference match, the hold-at-zero bit, self-clearing of run in single-run mode, flag setting with interrupt enable, and the output dropping after a disabling write. Only the bench scenarios can show the shape of the waveform over whole periods. They also cover flag-clear write semantics, readback of the stub bits, ignored misaligned writes and the one-cycle period with equal references. In those scenarios the behavioural model predicts `prdata`, `pwm_out` and `irq` on every clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Control word, bit 0 at the bottom of the packed struct
  typedef struct packed {
    logic cap_en;    // bit 8, stub
    logic cnt_clr;   // bit 7
    logic irq_flag;  // bit 6
    logic irq_en;    // bit 5
    logic one_shot;  // bit 4
    logic out_en;    // bit 3
    logic neg_edge;  // bit 2, stub
    logic ext_clk;   // bit 1, stub
    logic run;       // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_bus_regs.sv
module pwm_bus_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              lo_hit,
  output logic [DATA_W-1:0] prdata,
  output logic [DATA_W-1:0] hi_ref,
  output logic [DATA_W-1:0] lo_ref,
  output ctrl_t             ctrl,
  output logic              cnt_load
);

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_MSB = 3;

  logic     hi_zero;
  logic     addr_ok;
  reg_sel_e sel;
  logic     wr_acc;
  logic     wr_hi, wr_lo, wr_ctrl;

  if (ADDR_W > IDX_MSB + 1) begin : g_hi_bits
    assign hi_zero = (paddr[ADDR_W-1:IDX_MSB+1] == '0);
  end else begin : g_no_hi_bits
    assign hi_zero = 1'b1;
  end

  assign addr_ok = hi_zero && (paddr[IDX_LSB-1:0] == '0);
  assign sel     = reg_sel_e'(paddr[IDX_MSB:IDX_LSB]);
  assign wr_acc  = psel && penable && pwrite && addr_ok;

  assign cnt_load = wr_acc && (sel == SEL_CNT);
  assign wr_hi    = wr_acc && (sel == SEL_HI);
  assign wr_lo    = wr_acc && (sel == SEL_LO);
  assign wr_ctrl  = wr_acc && (sel == SEL_CTRL);

  // Reference registers
  logic [DATA_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_hi) begin
      hi_q <= pwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= pwdata;
    end
  end

  // Control register: bus write first, then hardware events on top
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d          = ctrl_t'(pwdata[CTRL_W-1:0]);
      ctrl_d.irq_flag = ctrl_q.irq_flag & pwdata[6];
    end
    if (lo_hit && ctrl_q.irq_en) begin
      ctrl_d.irq_flag = 1'b1;
    end
    if (lo_hit && ctrl_q.one_shot) begin
      ctrl_d.run = 1'b0;
    end
  end

  assign ctrl_en = wr_ctrl | lo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Read path
  always_comb begin
    prdata = '0;
    if (addr_ok) begin
      unique case (sel)
        SEL_CNT:  prdata = cnt_val;
        SEL_HI:   prdata = hi_q;
        SEL_LO:   prdata = lo_q;
        SEL_CTRL: prdata = DATA_W'(ctrl_q);
        default:  prdata = '0;
      endcase
    end
  end

  assign hi_ref = hi_q;
  assign lo_ref = lo_q;
  assign ctrl   = ctrl_q;

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              hold_zero,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] hi_ref,
  input  logic [DATA_W-1:0] lo_ref,
  output logic [DATA_W-1:0] cnt,
  output logic              hi_hit,
  output logic              lo_hit
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              live;

  assign live   = active && !hold_zero;
  assign hi_hit = live && (cnt_q == hi_ref);
  assign lo_hit = live && (cnt_q == lo_ref);

  always_comb begin
    cnt_d = cnt_q;
    if (hold_zero) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (active) begin
      cnt_d = lo_hit ? '0 : cnt_q + DATA_W'(1);
    end
  end

  assign cnt_en = hold_zero | load | active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hi_hit,
  input  logic lo_hit,
  input  logic irq_flag,
  input  logic irq_en,
  output logic pwm_out,
  output logic irq
);

  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (!active) begin
      lvl_d = 1'b0;
    end else if (lo_hit) begin
      lvl_d = 1'b0;
    end else if (hi_hit) begin
      lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign pwm_out = lvl_q & active;
  assign irq     = irq_flag & irq_en;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pwm_out,
  output logic              irq
);

  logic              rst_sync_n;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] hi_ref, lo_ref;
  ctrl_t             ctrl_q;
  logic              cnt_load;
  logic              hi_hit, lo_hit;
  logic              active;

  pwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .cnt_val  (cnt_q),
    .lo_hit   (lo_hit),
    .prdata   (prdata),
    .hi_ref   (hi_ref),
    .lo_ref   (lo_ref),
    .ctrl     (ctrl_q),
    .cnt_load (cnt_load)
  );

  assign active = ctrl_q.run & ctrl_q.out_en;

  pwm_count_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (active),
    .hold_zero (ctrl_q.cnt_clr),
    .load      (cnt_load),
    .load_val  (pwdata),
    .hi_ref    (hi_ref),
    .lo_ref    (lo_ref),
    .cnt       (cnt_q),
    .hi_hit    (hi_hit),
    .lo_hit    (lo_hit)
  );

  pwm_wave_out u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (active),
    .hi_hit   (hi_hit),
    .lo_hit   (lo_hit),
    .irq_flag (ctrl_q.irq_flag),
    .irq_en   (ctrl_q.irq_en),
    .pwm_out  (pwm_out),
    .irq      (irq)
  );

  assign pready = 1'b1;

endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] lo_ref,
  input ctrl_t             ctrl,
  input logic              pwm_out,
  input logic              irq
);

  logic wr_any, wr_cnt, wr_ctrl, running, at_lo;

  assign wr_any  = psel && penable && pwrite;
  assign wr_cnt  = wr_any && (paddr == ADDR_W'(0));
  assign wr_ctrl = wr_any && (paddr == ADDR_W'(12));
  assign running = ctrl.run && ctrl.out_en;
  assign at_lo   = running && !ctrl.cnt_clr && (cnt == lo_ref);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ctrl.cnt_clr && !wr_cnt && (cnt != lo_ref)) |=> (cnt == $past(cnt) + DATA_W'(1)));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lo && !wr_cnt) |=> (cnt == '0));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctrl.cnt_clr && !wr_cnt) |=> $stable(cnt));

  // R6
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (!pwdata[0] || !pwdata[3])) |=> !pwm_out);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lo && ctrl.irq_en && !wr_ctrl) |=> irq);

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lo && ctrl.one_shot) |=> !ctrl.run);

  // R10
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.cnt_clr |=> (cnt == '0));

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .cnt     (cnt_q),
  .lo_ref  (lo_ref),
  .ctrl    (ctrl_q),
  .pwm_out (pwm_out),
  .irq     (irq)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  logic          clk;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic          pready, pwm_out, irq;

  int    vecs;
  int    errs;
  string tag;

  pwm_timer_chan #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_cnt, m_hi, m_lo;
  logic [8:0]  m_ctrl;
  logic        m_lvl;

  always @(posedge clk) begin
    logic [31:0] n_cnt, n_hi, n_lo;
    logic [8:0]  n_ctrl;
    logic        n_lvl, act, clr, hit_lo, hit_hi, wr;
    if (!rst_n) begin
      m_cnt = 0; m_hi = 0; m_lo = 0; m_ctrl = 0; m_lvl = 0;
    end else begin
      wr     = psel && penable && pwrite && (paddr[1:0] == 2'b00);
      act    = m_ctrl[0] && m_ctrl[3];
      clr    = m_ctrl[7];
      hit_lo = act && !clr && (m_cnt == m_lo);
      hit_hi = act && !clr && (m_cnt == m_hi);
      n_cnt = m_cnt; n_hi = m_hi; n_lo = m_lo; n_ctrl = m_ctrl;
      if (clr) n_cnt = 0;
      else if (wr && paddr[3:2] == 2'd0) n_cnt = pwdata;
      else if (act) n_cnt = hit_lo ? 32'd0 : m_cnt + 32'd1;
      if (wr && paddr[3:2] == 2'd1) n_hi = pwdata;
      if (wr && paddr[3:2] == 2'd2) n_lo = pwdata;
      if (wr && paddr[3:2] == 2'd3) begin
        n_ctrl    = pwdata[8:0];
        n_ctrl[6] = m_ctrl[6] & pwdata[6];
      end
      if (hit_lo && m_ctrl[5]) n_ctrl[6] = 1'b1;
      if (hit_lo && m_ctrl[4]) n_ctrl[0] = 1'b0;
      if (!act) n_lvl = 1'b0;
      else if (hit_lo) n_lvl = 1'b0;
      else if (hit_hi) n_lvl = 1'b1;
      else n_lvl = m_lvl;
      m_cnt = n_cnt; m_hi = n_hi; m_lo = n_lo; m_ctrl = n_ctrl; m_lvl = n_lvl;
    end
  end

  function automatic logic [31:0] model_read(logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return 32'd0;
    case (a[3:2])
      2'd0:    return m_cnt;
      2'd1:    return m_hi;
      2'd2:    return m_lo;
      default: return {23'd0, m_ctrl};
    endcase
  endfunction

  task automatic check_bit(string what, logic act_v, logic exp_v);
    vecs++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act_v, exp_v);
    end
  endtask

  task automatic compare_all();
    logic [31:0] exp_rd;
    exp_rd = model_read(paddr);
    vecs++;
    if (prdata !== exp_rd) begin
      errs++;
      $display("FAIL %s prdata@%0h actual=%0h expected=%0h", tag, paddr, prdata, exp_rd);
    end
    check_bit("pwm_out", pwm_out, m_lvl & m_ctrl[0] & m_ctrl[3]);
    check_bit("irq", irq, m_ctrl[6] & m_ctrl[5]);
    check_bit("pready", pready, 1'b1);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic watch(logic [AW-1:0] a);
    paddr = a;
    step();
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    step();
    penable = 1'b1;
    step();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
  endtask

  initial begin
    vecs = 0; errs = 0; tag = "R1";
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents
    tag = "R1";
    watch(4'h0); watch(4'h4); watch(4'h8); watch(4'hC);

    // R2: register map and readback
    tag = "R2";
    bus_wr(4'h4, 32'd3);
    bus_wr(4'h8, 32'd9);
    watch(4'h4); watch(4'h8);
    bus_wr(4'h5, 32'hFF);  // misaligned, ignored
    watch(4'h4); watch(4'h5);

    // R11: counter load
    tag = "R11";
    bus_wr(4'h0, 32'd5);
    watch(4'h0);
    bus_wr(4'h0, 32'd0);

    // R3: counting and restart
    tag = "R3";
    bus_wr(4'hC, 32'h009);
    run(25);
    // R4: waveform over several periods
    tag = "R4";
    run(22);

    // R6: clearing output-enable drops output at once
    tag = "R6";
    bus_wr(4'hC, 32'h001);
    // R5: counter frozen while not running
    tag = "R5";
    run(6);

    // R7: interrupt flag and line
    tag = "R7";
    bus_wr(4'h0, 32'd0);
    bus_wr(4'hC, 32'h029);
    run(14);
    watch(4'hC);

    // R8: write 1 keeps, write 0 clears, write 1 never sets
    tag = "R8";
    bus_wr(4'hC, 32'h069);
    watch(4'hC);
    bus_wr(4'hC, 32'h020);
    watch(4'hC);
    bus_wr(4'hC, 32'h060);
    watch(4'hC);

    // R9: single-run self-clears run
    tag = "R9";
    bus_wr(4'h0, 32'd0);
    bus_wr(4'hC, 32'h019);
    run(16);
    watch(4'hC);
    watch(4'h0);

    // R10: counter clear holds zero
    tag = "R10";
    bus_wr(4'hC, 32'h089);
    run(6);
    bus_wr(4'h0, 32'd7);
    watch(4'h0);
    bus_wr(4'hC, 32'h009);
    run(6);

    // R12: stub bits stored, no effect
    tag = "R12";
    bus_wr(4'hC, 32'h10F);
    watch(4'hC);
    paddr = 4'h0;
    run(15);

    // R4: one-cycle period and equal references
    tag = "R4";
    bus_wr(4'hC, 32'h000);
    bus_wr(4'h4, 32'd0);
    bus_wr(4'h8, 32'd0);
    bus_wr(4'h0, 32'd0);
    bus_wr(4'hC, 32'h009);
    run(6);
    bus_wr(4'h4, 32'd4);
    bus_wr(4'h8, 32'd4);
    run(12);
    bus_wr(4'h4, 32'd1);
    run(12);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule